// File: doc/BRIEF.md
# 8-bit ALU with Status Flag Register

This block is the arithmetic and logic unit of an 8-bit accumulator machine, together with the register that holds its status flags. Each cycle it takes an accumulator operand, a second operand, a 4-bit operation code and a carry-in. It returns the 8-bit result combinationally and an accumulator write strobe. When the flag-write enable is high, it updates the five status flags (sign, zero, half carry, parity, carry) on the next rising clock edge. The flags are packed into one byte.

Each operation class has its own subset of flags that it changes. Full add and subtract update all five flags. Step operations (increment and decrement) keep the carry. Rotates touch only the carry. Bitwise operations always clear carry and half carry. Compare works out a subtraction for its flags only and does not ask for the accumulator to be written. Instruction decode and the register file sit outside this block.

Top module: `alu8_core`

## Requirements
- R1: Opcode 0 (add) gives result = (a + b) mod 256 and opcode 1 (add with carry) gives (a + b + carry_in) mod 256. CY becomes the carry out of bit 7, and acc_we is 1.
- R2: Opcode 2 (subtract) gives (a - b) mod 256 and opcode 3 (subtract with borrow) gives (a - b - carry_in) mod 256. CY becomes 1 exactly when the true difference is negative (borrow), and acc_we is 1.
- R3: Opcode 7 (compare) updates all five flags exactly as opcode 2 would. acc_we is 0, so the accumulator is not written.
- R4: Opcode 8 (increment) gives a + 1 and opcode 9 (decrement) gives a - 1, both mod 256. Both update S, Z, AC and P, and leave CY unchanged.
- R5: Opcodes 4 (AND), 5 (XOR) and 6 (OR) give the bitwise result of a and b. They update S, Z and P, and clear both CY and AC.
- R6: Opcode 10 rotates a left with bit 7 wrapping to bit 0. Opcode 11 rotates right with bit 0 wrapping to bit 7. Opcode 12 rotates left through carry: carry_in enters bit 0. Opcode 13 rotates right through carry: carry_in enters bit 7. CY takes the bit shifted out, S, Z, AC and P stay unchanged, and acc_we is 1.
- R7: Whenever S and Z are updated, S equals bit 7 of the result and Z is 1 exactly when the result is 0x00.
- R8: AC is the carry out of bit 3 of the internal addition. For subtract, subtract with borrow and compare, that addition is a + ~b + (1 - borrow_in). For decrement it is a + 0xFF. For increment it is a + 1.
- R9: Whenever P is updated, it is 1 exactly when the result has an even number of one bits.
- R10: The flag byte is {S, Z, 0, AC, 0, P, 1, CY}, with S at bit 7 and CY at bit 0. After reset (rst_n low, active low, asynchronous) it reads 0x02.
- R11: With flag_we low, the flag byte keeps its value across the clock edge, whatever the operation.
- R12: Opcodes 14 and 15 are idle codes. The result equals a, acc_we is 0, and the flag byte is unchanged even when flag_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code |
| a | input | 8 | Accumulator operand |
| b | input | 8 | Second operand |
| carry_in | input | 1 | Carry or borrow into the operation |
| flag_we | input | 1 | Flag register write enable |
| result | output | 8 | Combinational result |
| acc_we | output | 1 | Result should be written to the accumulator |
| flags | output | 8 | Registered packed flag byte |

## Verification
The hardest thing to show from the ports is that a flag was left alone on purpose. Proving that increment keeps CY, or that a rotate keeps S, Z, AC and P, needs the untouched flag to hold a value that the operation would have changed. Uniform random operands seldom set up that state. So the stimulus places directed operations before these cases: first a subtract that borrows, or an add that sets AC and odd parity, then an increment of 0xFF or a rotate of a zero operand. The random phase draws the opcode and carry_in independently, so each class often follows a flag state left behind by a different class.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_RLC  = 4'd10,
    OP_RRC  = 4'd11,
    OP_RAL  = 4'd12,
    OP_RAR  = 4'd13,
    OP_IDL0 = 4'd14,
    OP_IDL1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flag_set_t;

  // update-mask bit positions
  localparam int MB_S  = 4;
  localparam int MB_Z  = 3;
  localparam int MB_AC = 2;
  localparam int MB_P  = 1;
  localparam int MB_CY = 0;

  localparam logic [4:0] MASK_ALL   = 5'b11111;
  localparam logic [4:0] MASK_NO_CY = 5'b11110;
  localparam logic [4:0] MASK_CY    = 5'b00001;
  localparam logic [4:0] MASK_NONE  = 5'b00000;

  function automatic logic [7:0] pack_flags(flag_set_t f);
    return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
  endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hc
);
  localparam int H = W / 2;
  localparam int U = W - H;

  logic [H:0] lo;
  logic [U:0] hi;

  // split so the half carry is a real intermediate, not a recomputation
  always_comb begin
    lo = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, cin};
    hi = {1'b0, x[W-1:H]} + {1'b0, y[W-1:H]} + {{U{1'b0}}, lo[H]};
  end

  assign sum  = {hi[U-1:0], lo[H-1:0]};
  assign cout = hi[U];
  assign hc   = lo[H];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         shout
);
  always_comb begin
    res   = a;
    shout = 1'b0;
    unique case (op)
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_OR:  res = a | b;
      OP_RLC: begin res = {a[W-2:0], a[W-1]}; shout = a[W-1]; end
      OP_RRC: begin res = {a[0], a[W-1:1]};   shout = a[0];   end
      OP_RAL: begin res = {a[W-2:0], cin};    shout = a[W-1]; end
      OP_RAR: begin res = {cin, a[W-1:1]};    shout = a[0];   end
      default: begin res = a; shout = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg import alu8_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      we,
  input  logic [4:0] mask,
  input  flag_set_t d,
  output flag_set_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (we) begin
      if (mask[MB_S])  q.s  <= d.s;
      if (mask[MB_Z])  q.z  <= d.z;
      if (mask[MB_AC]) q.ac <= d.ac;
      if (mask[MB_P])  q.p  <= d.p;
      if (mask[MB_CY]) q.cy <= d.cy;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core import alu8_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_in,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         acc_we,
  output logic [7:0]   flags
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

  alu_op_e opc;
  assign opc = alu_op_e'(op);

  // operation class decode, brought out for the checker
  logic is_add, is_sub, is_step, is_logic, is_rot, is_idle;
  always_comb begin
    is_add   = (opc == OP_ADD) || (opc == OP_ADC);
    is_sub   = (opc == OP_SUB) || (opc == OP_SBB) || (opc == OP_CMP);
    is_step  = (opc == OP_INC) || (opc == OP_DEC);
    is_logic = (opc == OP_AND) || (opc == OP_XOR) || (opc == OP_OR);
    is_rot   = (opc >= OP_RLC) && (opc <= OP_RAR);
    is_idle  = (opc == OP_IDL0) || (opc == OP_IDL1);
  end

  // adder operand preparation: subtraction is a + ~b + !borrow
  logic [W-1:0] add_y;
  logic         add_cin;
  logic         borrow_in;
  always_comb begin
    borrow_in = (opc == OP_SBB) ? carry_in : 1'b0;
    add_y     = b;
    add_cin   = 1'b0;
    if (is_add) begin
      add_y   = b;
      add_cin = (opc == OP_ADC) ? carry_in : 1'b0;
    end else if (is_sub) begin
      add_y   = ~b;
      add_cin = ~borrow_in;
    end else if (opc == OP_INC) begin
      add_y   = ONE;
      add_cin = 1'b0;
    end else if (opc == OP_DEC) begin
      add_y   = ALL_ONES;
      add_cin = 1'b0;
    end
  end

  logic [W-1:0] arith_sum;
  logic         arith_cout;
  logic         half_carry;

  alu8_adder #(.W(W)) u_add (
    .x    (a),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (arith_sum),
    .cout (arith_cout),
    .hc   (half_carry)
  );

  logic [W-1:0] lu_res;
  logic         rot_shout;

  alu8_logic #(.W(W)) u_lu (
    .op    (opc),
    .a     (a),
    .b     (b),
    .cin   (carry_in),
    .res   (lu_res),
    .shout (rot_shout)
  );

  // result selection
  always_comb begin
    if (is_add || is_sub || is_step) result = arith_sum;
    else if (is_logic || is_rot)     result = lu_res;
    else                             result = a;
  end

  assign acc_we = !(is_idle || (opc == OP_CMP));

  // flag candidates and which of them this op may change
  logic      res_zero;
  logic      res_even;
  flag_set_t flag_nx;
  logic [4:0] upd_mask;

  assign res_zero = (result == '0);
  assign res_even = ~^result;

  always_comb begin
    flag_nx.s  = result[W-1];
    flag_nx.z  = res_zero;
    flag_nx.p  = res_even;
    flag_nx.ac = (is_logic) ? 1'b0 : half_carry;
    if (is_add)        flag_nx.cy = arith_cout;
    else if (is_sub)   flag_nx.cy = ~arith_cout;
    else if (is_rot)   flag_nx.cy = rot_shout;
    else               flag_nx.cy = 1'b0;
  end

  always_comb begin
    if (is_add || is_sub || is_logic) upd_mask = MASK_ALL;
    else if (is_step)                 upd_mask = MASK_NO_CY;
    else if (is_rot)                  upd_mask = MASK_CY;
    else                              upd_mask = MASK_NONE;
  end

  flag_set_t flag_q;

  alu8_flagreg u_freg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flag_we),
    .mask  (upd_mask),
    .d     (flag_nx),
    .q     (flag_q)
  );

  assign flags = pack_flags(flag_q);
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic         acc_we,
  input logic [7:0]   flags,
  input logic [4:0]   upd_mask
);
  AST_SIGN_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && upd_mask[4]) |=> (flags[7] == $past(result[W-1]))); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && upd_mask[3]) |=> (flags[6] == ($past(result) == '0))); // R7
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && upd_mask[1]) |=> (flags[2] == ($countones($past(result)) % 2 == 0))); // R9
  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[5] == 1'b0) && (flags[3] == 1'b0) && (flags[1] == 1'b1)); // R10
  AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags)); // R11
  AST_CMP_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd7) |-> !acc_we); // R3
  AST_STEP_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op == 4'd8 || op == 4'd9)) |=> $stable(flags[0])); // R4
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op >= 4'd4 && op <= 4'd6) |=> (flags[0] == 1'b0 && flags[4] == 1'b0)); // R5
  AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op >= 4'd10 && op <= 4'd13) |=> $stable(flags[7:1])); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd14) |=> $stable(flags)); // R12
  AST_IDLE_NO_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 4'd14) |-> !acc_we); // R12
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op       (op),
  .flag_we  (flag_we),
  .result   (result),
  .acc_we   (acc_we),
  .flags    (flags),
  .upd_mask (upd_mask)
);

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a, b;
  logic       carry_in;
  logic       flag_we;
  logic [7:0] result;
  logic       acc_we;
  logic [7:0] flags;

  int n_chk  = 0;
  int n_fail = 0;

  // expected flag state
  logic e_s = 0, e_z = 0, e_ac = 0, e_p = 0, e_cy = 0;

  always #10 clk = ~clk;

  alu8_core dut (
    .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .carry_in(carry_in),
    .flag_we(flag_we), .result(result), .acc_we(acc_we), .flags(flags)
  );

  function automatic string tag_of(input logic [3:0] o);
    if (o <= 4'd1) return "R1";
    if (o == 4'd2 || o == 4'd3) return "R2";
    if (o == 4'd7) return "R3";
    if (o == 4'd8 || o == 4'd9) return "R4";
    if (o >= 4'd4 && o <= 4'd6) return "R5";
    if (o >= 4'd10 && o <= 4'd13) return "R6";
    return "R12";
  endfunction

  function automatic logic even_ones(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return (c % 2) == 0;
  endfunction

  function automatic logic [7:0] exp_byte();
    return {e_s, e_z, 1'b0, e_ac, 1'b0, e_p, 1'b1, e_cy};
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic c, input logic we);
    int ai, bi, ci, t;
    logic [7:0] r;
    logic wacc, ns, nz, nac, np, ncy;
    logic [4:0] m;
    ai = x; bi = y; ci = c;
    r = x; wacc = 1'b1; nac = 1'b0; ncy = 1'b0; m = 5'b11111;
    case (o)
      4'd0, 4'd1: begin
        if (o == 4'd0) ci = 0;
        t = ai + bi + ci; r = 8'(t); ncy = (t > 255);
        nac = ((ai % 16) + (bi % 16) + ci) > 15;
      end
      4'd2, 4'd3, 4'd7: begin
        if (o != 4'd3) ci = 0;
        t = ai - bi - ci; r = 8'(t); ncy = (t < 0);
        nac = ((ai % 16) + (15 - (bi % 16)) + (1 - ci)) > 15;
        wacc = (o != 4'd7);
      end
      4'd8: begin r = 8'(ai + 1); nac = (ai % 16) == 15; m = 5'b11110; end
      4'd9: begin r = 8'(ai + 255); nac = (ai % 16) != 0; m = 5'b11110; end
      4'd4: r = x & y;
      4'd5: r = x ^ y;
      4'd6: r = x | y;
      4'd10: begin r = 8'((ai * 2) % 256 + ai / 128); ncy = x[7]; m = 5'b00001; end
      4'd11: begin r = 8'(ai / 2 + (ai % 2) * 128);   ncy = x[0]; m = 5'b00001; end
      4'd12: begin r = 8'((ai * 2) % 256 + ci);       ncy = x[7]; m = 5'b00001; end
      4'd13: begin r = 8'(ai / 2 + ci * 128);         ncy = x[0]; m = 5'b00001; end
      default: begin r = x; wacc = 1'b0; m = 5'b00000; end
    endcase
    ns = r[7]; nz = (r == 8'h00); np = even_ones(r);

    @(negedge clk);
    op = o; a = x; b = y; carry_in = c; flag_we = we;
    #2;
    n_chk++;
    if (result !== r || acc_we !== wacc) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d: result/acc_we actual %h/%0b expected %h/%0b",
               tag_of(o), o, x, y, c, result, acc_we, r, wacc);
    end
    if (we) begin
      if (m[4]) e_s = ns;
      if (m[3]) e_z = nz;
      if (m[2]) e_ac = nac;
      if (m[1]) e_p = np;
      if (m[0]) e_cy = ncy;
    end
    @(posedge clk);
    #2;
    n_chk++;
    if (flags !== exp_byte()) begin
      n_fail++;
      $display("FAIL %s flags (R7/R8/R9/R11) op=%0d a=%h b=%h c=%0d we=%0b: actual %h expected %h",
               tag_of(o), o, x, y, c, we, flags, exp_byte());
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unused;
    unused = $urandom(32'd24681);
    rst_n = 1'b0; op = 4'd14; a = 0; b = 0; carry_in = 0; flag_we = 0;
    repeat (3) @(posedge clk);
    #2;
    n_chk++;  // R10 reset value
    if (flags !== 8'h02) begin
      n_fail++;
      $display("FAIL R10 reset flags actual %h expected 02", flags);
    end
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    apply(4'd0, 8'h0F, 8'h01, 1'b0, 1'b1);   // R8 half carry, R1
    apply(4'd0, 8'hFF, 8'h01, 1'b0, 1'b1);   // R1 carry, R7 zero
    apply(4'd1, 8'hFE, 8'h01, 1'b1, 1'b1);   // R1 adc wraps to zero
    apply(4'd2, 8'h00, 8'h01, 1'b0, 1'b1);   // R2 borrow
    apply(4'd8, 8'hFF, 8'h00, 1'b0, 1'b1);   // R4 CY stays 1 while result wraps
    apply(4'd3, 8'h10, 8'h0F, 1'b1, 1'b1);   // R2 sbb with borrow in
    apply(4'd9, 8'h00, 8'h00, 1'b0, 1'b1);   // R4 dec through zero, CY kept
    apply(4'd7, 8'h42, 8'h42, 1'b0, 1'b1);   // R3 equal compare
    apply(4'd7, 8'h10, 8'h20, 1'b0, 1'b1);   // R3 compare borrow
    apply(4'd0, 8'h07, 8'h09, 1'b0, 1'b1);   // set AC, odd parity
    apply(4'd10, 8'h00, 8'h00, 1'b0, 1'b1);  // R6 rotate must keep S Z AC P
    apply(4'd10, 8'h81, 8'h00, 1'b0, 1'b1);  // R6
    apply(4'd11, 8'h81, 8'h00, 1'b0, 1'b1);  // R6
    apply(4'd12, 8'h80, 8'h00, 1'b1, 1'b1);  // R6 through carry
    apply(4'd13, 8'h01, 8'h00, 1'b1, 1'b1);  // R6 through carry
    apply(4'd4, 8'hF0, 8'h3C, 1'b1, 1'b1);   // R5
    apply(4'd5, 8'hAA, 8'hAA, 1'b1, 1'b1);   // R5 zero
    apply(4'd6, 8'h00, 8'h80, 1'b0, 1'b1);   // R5 sign
    apply(4'd2, 8'h00, 8'h01, 1'b0, 1'b1);   // set flags
    apply(4'd0, 8'h01, 8'h01, 1'b0, 1'b0);   // R11 hold
    apply(4'd14, 8'h5A, 8'h11, 1'b1, 1'b1);  // R12 idle with write enable
    apply(4'd15, 8'h00, 8'hFF, 1'b0, 1'b1);  // R12

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] ro;
      logic [7:0] ra, rb;
      ro = 4'($urandom_range(0, 15));
      ra = 8'($urandom);
      rb = 8'($urandom);
      if ($urandom_range(0, 7) == 0) rb = ra;
      apply(ro, ra, rb, 1'($urandom), ($urandom_range(0, 4) != 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule